// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is a 32-bit arithmetic unit for multiplication and division. It keeps its results in two private result registers, HI and LO. A host issues an operation with a one-cycle start strobe, an opcode and two operands. It collects results through a read port that returns either register.

Multiplies and the 64-bit multiply-accumulate and multiply-subtract forms finish in the same cycle. Division is iterative and yields one quotient bit per clock, so a divide holds the unit busy for 32 cycles. Division by zero and the signed overflow case skip the iteration and finish at once, with fixed results. While the unit is busy, a read request is answered with a stall indication instead of data. A read whose destination register index is zero is suppressed.

Top module: `hilo_muldiv`

## Requirements
- R1: After a synchronous active-low reset, HI and LO are both zero and `busy` is low.
- R2: Opcode 0 (signed multiply) and opcode 1 (unsigned multiply) write the 64-bit product of `opa` and `opb`. LO takes bits 31:0 and HI takes bits 63:32. The result is readable in the cycle after the start.
- R3: The four accumulate opcodes treat {HI,LO} as one 64-bit value. Opcode 2 adds the signed product and opcode 3 adds the unsigned product. Opcode 4 subtracts the signed product and opcode 5 subtracts the unsigned product. All wrap modulo 2^64.
- R4: Opcode 6 (signed divide) and opcode 7 (unsigned divide) are handled here when the divisor is non-zero and the operands are not the overflow pair. LO receives the quotient truncated toward zero. HI receives the remainder, which carries the sign of the dividend.
- R5: A signed divide of 0x80000000 by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0xFFFFFFFF.
- R6: A signed divide by zero gives HI = dividend. LO is 1 when the dividend is negative and 0xFFFFFFFF otherwise.
- R7: An unsigned divide by zero gives HI = dividend. LO is 0x0000FFFF when the dividend is at most 0xFFFF and 0xFFFFFFFF otherwise.
- R8: The results of R5, R6 and R7 are written in the cycle after the start, and `busy` never rises for them.
- R9: Any other divide raises `busy` in the cycle after the start and holds it for exactly 32 cycles. HI and LO receive the results on the clock edge at which `busy` falls.
- R10: Two kinds of start change nothing. A start while `busy` is high is ignored. A start with an opcode of 10 to 15 is also ignored.
- R11: Opcode 8 loads `opa` into HI and opcode 9 loads `opa` into LO. The new value is visible in the next cycle.
- R12: The read port is combinational. It returns HI when `rd_hi` is 1 and LO otherwise. `rd_ack` is high only when a request is made while idle with a non-zero `rd_dst`, and `rd_data` is zero whenever `rd_ack` is low.
- R13: A read request while `busy` is high raises `rd_stall` and gives no `rd_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle operation strobe |
| op | input | 4 | Opcode (see R2 to R11) |
| opa | input | 32 | First operand or dividend |
| opb | input | 32 | Second operand or divisor |
| busy | output | 1 | Iterative divide in progress |
| rd_req | input | 1 | Read request |
| rd_hi | input | 1 | Select HI (1) or LO (0) |
| rd_dst | input | 5 | Destination register index of the read |
| rd_data | output | 32 | Selected register value when acknowledged |
| rd_ack | output | 1 | Read accepted |
| rd_stall | output | 1 | Read must wait for the divide to finish |

## Verification
Two pairs of events can fall in the same cycle, and the bench drives both on purpose.

The first pair is a read request and a running divide. The bench holds `rd_req` high through whole divides. It then judges, every clock, that `rd_stall` and `rd_ack` change over exactly at the edge where `busy` falls, and that the acknowledged data is already the new quotient or remainder.

The second pair is a new start and a running divide. The bench issues register loads, multiplies and further divides at several points inside the 32-cycle window. The behavioural reference drops each of them, so HI and LO must match a model in which those starts never happened.

// File: rtl/hilo_md_pkg.sv
// Shared opcode encoding for the HI/LO multiply-divide unit.
package hilo_md_pkg;
    typedef enum logic [3:0] {
        OP_MUL_S = 4'd0,
        OP_MUL_U = 4'd1,
        OP_MAC_S = 4'd2,
        OP_MAC_U = 4'd3,
        OP_MSB_S = 4'd4,
        OP_MSB_U = 4'd5,
        OP_DIV_S = 4'd6,
        OP_DIV_U = 4'd7,
        OP_SET_HI = 4'd8,
        OP_SET_LO = 4'd9
    } md_op_e;

    // Accumulate mode handed to the multiplier.
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_ADD  = 2'd1,
        ACC_SUB  = 2'd2
    } acc_mode_e;
endpackage

// File: rtl/hilo_mul.sv
// Single-cycle multiplier with optional 64-bit accumulate or subtract.
// Assumes: operands are sign- or zero-extended to 2W bits as selected by
// sgn; the truncated 2W-bit product is then exact in both cases.
module hilo_mul
    import hilo_md_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           sgn,
    input  acc_mode_e      mode,
    input  logic [2*W-1:0] acc,
    output logic [2*W-1:0] res
);
    logic [2*W-1:0] ext_a, ext_b, prod;

    // Extend the operands, form the product and combine it with the accumulator.
    always_comb begin
        ext_a = sgn ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
        ext_b = sgn ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
        prod  = ext_a * ext_b;
        case (mode)
            ACC_ADD: res = acc + prod;
            ACC_SUB: res = acc - prod;
            default: res = prod;
        endcase
    end
endmodule

// File: rtl/hilo_div_special.sv
// Detects the divide cases that finish without iterating and supplies their results.
// Assumes: the caller consults hit only for divide opcodes.
module hilo_div_special #(
    parameter int W = 32
) (
    input  logic         sgn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         hit,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int HW = W / 2;
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ALL_ONE = {W{1'b1}};
    localparam logic [W-1:0] HALF_ONES = {{(W-HW){1'b0}}, {HW{1'b1}}};

    // Classify the operand pair and select the fixed result.
    always_comb begin
        hit = 1'b0;
        quo = '0;
        rem = '0;
        if (b == '0) begin
            hit = 1'b1;
            rem = a;
            if (sgn)
                quo = a[W-1] ? {{(W-1){1'b0}}, 1'b1} : ALL_ONE;
            else
                quo = (a[W-1:HW] == '0) ? HALF_ONES : ALL_ONE;
        end else if (sgn && a == MIN_NEG && b == ALL_ONE) begin
            hit = 1'b1;
            quo = MIN_NEG;
            rem = ALL_ONE;
        end
    end
endmodule

// File: rtl/hilo_div.sv
// Restoring divider producing one quotient bit per cycle on magnitudes.
// Assumes: go is raised only while idle and never for the special cases.
// fin is high in the last busy cycle; quo/rem are valid then.
module hilo_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic         sgn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         busy,
    output logic         fin,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [W-1:0]  rem_q, quo_q, dvs_q, rem_n, quo_n;
    logic [CW-1:0] cnt_q;
    logic          negq_q, negr_q, busy_q;
    logic [W:0]    trial;

    // One restoring step: shift in the next dividend bit and try to subtract.
    always_comb begin
        trial = {rem_q, quo_q[W-1]} - {1'b0, dvs_q};
        if (!trial[W]) begin
            rem_n = trial[W-1:0];
            quo_n = {quo_q[W-2:0], 1'b1};
        end else begin
            rem_n = {rem_q[W-2:0], quo_q[W-1]};
            quo_n = {quo_q[W-2:0], 1'b0};
        end
    end

    // Iteration state: load magnitudes on go, step while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            negq_q <= 1'b0;
            negr_q <= 1'b0;
        end else if (go && !busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            rem_q  <= '0;
            quo_q  <= (sgn && a[W-1]) ? -a : a;
            dvs_q  <= (sgn && b[W-1]) ? -b : b;
            negq_q <= sgn && (a[W-1] ^ b[W-1]);
            negr_q <= sgn && a[W-1];
        end else if (busy_q) begin
            rem_q <= rem_n;
            quo_q <= quo_n;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) busy_q <= 1'b0;
        end
    end

    assign busy = busy_q;
    assign fin  = busy_q && (cnt_q == LAST);
    assign quo  = negq_q ? -quo_n : quo_n;
    assign rem  = negr_q ? -rem_n : rem_n;
endmodule

// File: rtl/hilo_muldiv.sv
// Multiply-divide unit owning the HI and LO result registers.
// Assumes: one operation per start strobe; starts during a divide are dropped.
// The read port is combinational and stalls while a divide is running.
module hilo_muldiv
    import hilo_md_pkg::*;
#(
    parameter int W    = 32,
    parameter int REGW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [3:0]      op,
    input  logic [W-1:0]    opa,
    input  logic [W-1:0]    opb,
    output logic            busy,
    input  logic            rd_req,
    input  logic            rd_hi,
    input  logic [REGW-1:0] rd_dst,
    output logic [W-1:0]    rd_data,
    output logic            rd_ack,
    output logic            rd_stall
);
    logic [W-1:0]   hi_q, lo_q;
    md_op_e         opc;
    logic           accept, is_mul, is_div, sgn;
    acc_mode_e      mode;
    logic [2*W-1:0] mres;
    logic           sp_hit;
    logic [W-1:0]   sp_quo, sp_rem, dv_quo, dv_rem;
    logic           dv_busy, dv_fin, dv_go;

    // Decode the opcode into unit controls.
    always_comb begin
        opc    = md_op_e'(op);
        is_mul = (op <= 4'd5);
        is_div = (opc == OP_DIV_S) || (opc == OP_DIV_U);
        sgn    = ~op[0];
        accept = start && !dv_busy && (op <= 4'd9);
        case (opc)
            OP_MAC_S, OP_MAC_U: mode = ACC_ADD;
            OP_MSB_S, OP_MSB_U: mode = ACC_SUB;
            default:            mode = ACC_NONE;
        endcase
        dv_go = accept && is_div && !sp_hit;
    end

    hilo_mul #(.W(W)) u_mul (
        .a(opa), .b(opb), .sgn(sgn), .mode(mode),
        .acc({hi_q, lo_q}), .res(mres)
    );

    hilo_div_special #(.W(W)) u_spec (
        .sgn(sgn), .a(opa), .b(opb),
        .hit(sp_hit), .quo(sp_quo), .rem(sp_rem)
    );

    hilo_div #(.W(W)) u_div (
        .clk(clk), .rst_n(rst_n), .go(dv_go), .sgn(sgn), .a(opa), .b(opb),
        .busy(dv_busy), .fin(dv_fin), .quo(dv_quo), .rem(dv_rem)
    );

    // Result registers: written by accepted operations or divide completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (accept) begin
            if (is_mul) begin
                hi_q <= mres[2*W-1:W];
                lo_q <= mres[W-1:0];
            end else if (is_div) begin
                if (sp_hit) begin
                    hi_q <= sp_rem;
                    lo_q <= sp_quo;
                end
            end else if (opc == OP_SET_HI) begin
                hi_q <= opa;
            end else begin
                lo_q <= opa;
            end
        end else if (dv_fin) begin
            hi_q <= dv_rem;
            lo_q <= dv_quo;
        end
    end

    // Read port: select, suppress zero destination, stall while dividing.
    always_comb begin
        rd_stall = rd_req && dv_busy;
        rd_ack   = rd_req && !dv_busy && (rd_dst != '0);
        rd_data  = rd_ack ? (rd_hi ? hi_q : lo_q) : '0;
    end

    assign busy = dv_busy;
endmodule

// File: rtl/hilo_muldiv_chk.sv
// Property checker for hilo_muldiv, attached by bind.
module hilo_muldiv_chk #(
    parameter int W    = 32,
    parameter int REGW = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [3:0]      op,
    input logic [W-1:0]    opa,
    input logic [W-1:0]    opb,
    input logic            busy,
    input logic            rd_ack,
    input logic [REGW-1:0] rd_dst,
    input logic [W-1:0]    hi_q,
    input logic [W-1:0]    lo_q
);
    localparam int CW = $clog2(W) + 1;
    logic [CW-1:0] bcnt;

    // Count consecutive busy cycles to check the divide window length.
    always_ff @(posedge clk) begin
        if (!rst_n) bcnt <= '0;
        else if (busy) bcnt <= bcnt + 1'b1;
        else bcnt <= '0;
    end

    assert_busy_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start) && ($past(op) == 4'd6 || $past(op) == 4'd7));
    assert_busy_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> bcnt == CW'(W));
    assert_busy_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> bcnt < CW'(W));
    assert_hold_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bcnt < CW'(W - 1)) |=> $stable(hi_q) && $stable(lo_q));
    assert_no_ack_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rd_ack);
    assert_zero_dst_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_dst == '0 |-> !rd_ack);
    assert_set_hi_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op == 4'd8) |=> hi_q == $past(opa));
    assert_zero_div_fast_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (op == 4'd6 || op == 4'd7) && opb == '0) |=> !busy);
endmodule

bind hilo_muldiv hilo_muldiv_chk #(.W(W), .REGW(REGW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
    .busy(busy), .rd_ack(rd_ack), .rd_dst(rd_dst), .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/test_hilo_muldiv.sv
// Bench: behavioural reference model compared against the unit on every clock.
module test_hilo_muldiv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op = '0;
    logic [31:0] opa = '0, opb = '0;
    logic        busy;
    logic        rd_req = 1'b0, rd_hi = 1'b0;
    logic [4:0]  rd_dst = 5'd1;
    logic [31:0] rd_data;
    logic        rd_ack, rd_stall;

    int compared = 0, mismatched = 0, cycles = 0;
    bit finished = 0;
    string cur_tag = "R1";

    logic [31:0] m_hi, m_lo, p_hi, p_lo;
    int          m_cnt;

    always #4 clk = ~clk;

    hilo_muldiv i_hilo_muldiv (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
        .busy(busy), .rd_req(rd_req), .rd_hi(rd_hi), .rd_dst(rd_dst),
        .rd_data(rd_data), .rd_ack(rd_ack), .rd_stall(rd_stall)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Reference model of one accepted operation.
    task automatic model_op();
        logic [63:0] acc, ps, pu;
        longint sa64, sb64;
        int sa, sb;
        acc  = {m_hi, m_lo};
        sa64 = longint'($signed(opa));
        sb64 = longint'($signed(opb));
        ps   = 64'(sa64 * sb64);
        pu   = {32'b0, opa} * {32'b0, opb};
        sa   = $signed(opa);
        sb   = $signed(opb);
        case (op)
            4'd0: {m_hi, m_lo} = ps;
            4'd1: {m_hi, m_lo} = pu;
            4'd2: {m_hi, m_lo} = acc + ps;
            4'd3: {m_hi, m_lo} = acc + pu;
            4'd4: {m_hi, m_lo} = acc - ps;
            4'd5: {m_hi, m_lo} = acc - pu;
            4'd6: begin
                if (sb == 0) begin
                    m_hi = opa;
                    m_lo = (sa < 0) ? 32'd1 : 32'hFFFF_FFFF;
                end else if (opa == 32'h8000_0000 && sb == -1) begin
                    m_hi = 32'hFFFF_FFFF;
                    m_lo = 32'h8000_0000;
                end else begin
                    p_lo = 32'(sa / sb);
                    p_hi = 32'(sa % sb);
                    m_cnt = 32;
                end
            end
            4'd7: begin
                if (opb == 0) begin
                    m_hi = opa;
                    m_lo = (opa <= 32'h0000_FFFF) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
                end else begin
                    p_lo = opa / opb;
                    p_hi = opa % opb;
                    m_cnt = 32;
                end
            end
            4'd8: m_hi = opa;
            4'd9: m_lo = opa;
            default: ;
        endcase
    endtask

    // Advance the model on each rising edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_hi = '0; m_lo = '0; m_cnt = 0;
        end else if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) begin m_hi = p_hi; m_lo = p_lo; end
        end else if (start) begin
            model_op();
        end
    end

    // Compare every output on the falling edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic ack_e;
            ack_e = rd_req && (m_cnt == 0) && (rd_dst != 0);
            chk("R9 busy", {31'b0, busy}, {31'b0, m_cnt > 0});
            chk("R13 stall", {31'b0, rd_stall}, {31'b0, rd_req && m_cnt > 0});
            chk("R12 ack", {31'b0, rd_ack}, {31'b0, ack_e});
            chk(cur_tag, rd_data, ack_e ? (rd_hi ? m_hi : m_lo) : 32'd0);
        end
    end

    task automatic issue(logic [3:0] o, logic [31:0] a, logic [31:0] b);
        @(posedge clk); #1;
        start = 1'b1; op = o; opa = a; opb = b;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic drain_and_read();
        while (busy) begin @(posedge clk); #1; end
        rd_req = 1'b1; rd_hi = 1'b0;
        @(posedge clk); #1;
        rd_hi = 1'b1;
        @(posedge clk); #1;
        rd_req = 1'b0;
    endtask

    task automatic run(string tag, logic [3:0] o, logic [31:0] a, logic [31:0] b);
        cur_tag = tag;
        issue(o, a, b);
        drain_and_read();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cycles > 50000 && !finished) begin
            finished = 1;
            mismatched++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #3;
        chk("R1 busy", {31'b0, busy}, 32'd0);
        cur_tag = "R1";
        drain_and_read();
        run("R2", 4'd0, 32'hFFFF_FFFE, 32'h0000_0003);
        run("R2", 4'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run("R2", 4'd0, 32'h8000_0000, 32'h8000_0000);
        run("R3", 4'd2, 32'hFFFF_FFFF, 32'h0000_0005);
        run("R3", 4'd3, 32'hFFFF_FFFF, 32'h0000_0005);
        run("R3", 4'd4, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
        run("R3", 4'd5, 32'h1234_5678, 32'h9ABC_DEF0);
        run("R4", 4'd6, 32'hFFFF_FFF9, 32'h0000_0002);
        run("R4", 4'd6, 32'h0000_0007, 32'hFFFF_FFFE);
        run("R4", 4'd6, 32'h8000_0000, 32'h0000_0003);
        run("R4", 4'd7, 32'hFFFF_FFFF, 32'h0000_0010);
        run("R4", 4'd7, 32'h0000_0003, 32'hFFFF_FFFF);
        run("R5", 4'd6, 32'h8000_0000, 32'hFFFF_FFFF);
        run("R6", 4'd6, 32'hFFFF_FF00, 32'h0);
        run("R6", 4'd6, 32'h0000_0000, 32'h0);
        run("R7", 4'd7, 32'h0000_FFFF, 32'h0);
        run("R7", 4'd7, 32'h0001_0000, 32'h0);
        // R8: special divide leaves busy low the cycle after start
        cur_tag = "R8";
        issue(4'd7, 32'h0000_0042, 32'h0);
        chk("R8 busy", {31'b0, busy}, 32'd0);
        drain_and_read();
        run("R11", 4'd8, 32'hCAFE_0001, 32'h0);
        run("R11", 4'd9, 32'hBEEF_0002, 32'h0);
        // R10: ignored opcodes and starts during a divide
        run("R10", 4'd12, 32'h1111_1111, 32'h2222_2222);
        cur_tag = "R10";
        issue(4'd6, 32'h0000_1000, 32'h0000_0007);
        issue(4'd8, 32'hDEAD_DEAD, 32'h0);
        repeat (5) @(posedge clk);
        #1;
        issue(4'd0, 32'h0000_0100, 32'h0000_0100);
        issue(4'd7, 32'h0000_0009, 32'h0);
        drain_and_read();
        // R13/R9: hold a read request across a whole divide
        cur_tag = "R13";
        rd_req = 1'b1; rd_hi = 1'b0;
        issue(4'd7, 32'h0F0F_0F0F, 32'h0000_0033);
        while (busy) begin @(posedge clk); #1; end
        @(posedge clk); #1;
        rd_hi = 1'b1;
        @(posedge clk); #1;
        // R12: zero destination suppressed while idle
        cur_tag = "R12";
        rd_dst = 5'd0;
        @(posedge clk); #1;
        rd_dst = 5'd31;
        @(posedge clk); #1;
        rd_req = 1'b0;
        @(posedge clk); #1;
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule